// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM with Late Write

This block models a single-port synchronous static RAM whose write data trails its address by one clock. Address and command are sampled on a rising edge. Write data and per-byte write strobes are sampled on the next enabled edge. Because of that delay, read and write commands can alternate on consecutive cycles without idle turnaround cycles. Reads are flow-through: the word at the captured address is registered on the same edge, so it is on the output during the following cycle. A read of an address whose write is being completed on that edge returns the new data.

An active-low clock enable freezes every register in the block. A load/advance input chooses between two actions. A load captures a fresh address and direction. An advance steps a two-bit burst counter in the low address bits and keeps the upper bits and the direction. A small controller tracks the burst state. Its states are IDLE (deselected), READ and WRITE. On a load, the next state is IDLE when chip select is high, READ when write enable is high, and WRITE when write enable is low. On an advance, every state holds its own value. Data input and output are on separate buses.

Top module: `sram_ft_top`

## Requirements
- R1: While `rst_n` is low, `rvalid` is 0 and `rdata` is 0.
- R2: On an edge with `ce_n`=0, `ld_n`=0, `sel_n`=0 and `we_n`=1, the address is captured. After that edge, `rdata` holds the stored word at that address and `rvalid` is 1.
- R3: On an edge with `ce_n`=0, `ld_n`=0, `sel_n`=0 and `we_n`=0, a write is captured and `rvalid` is 0 after that edge. The write data is taken from `wdata` and `bw_n` on the next edge with `ce_n`=0, and is stored on that edge.
- R4: Byte lane b occupies `wdata`/`rdata` bits [9b+8:9b]. The lane is written only when `bw_n[b]` is 0. Lanes whose strobe is 1 keep their old contents.
- R5: `wdata` and `bw_n` have no effect on storage on an enabled edge that follows a read, a deselect or an idle advance.
- R6: On an edge with `ce_n`=1, no register changes. `rdata` and `rvalid` hold, and a pending write waits for the next enabled edge.
- R7: An edge with `ce_n`=0 and `ld_n`=1 inside an active burst sets the low two address bits to their previous value plus 1, modulo 4. The upper bits and the read or write direction are kept.
- R8: A read of the address whose pending write is stored on the same edge returns the newly written lanes, merged with the old contents of the unwritten lanes.
- R9: A load with `sel_n`=1 enters IDLE. `rvalid` is 0 afterwards, no storage is accessed, and advances keep the block in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low clock enable |
| sel_n | input | 1 | Active-low chip select, sampled on loads |
| ld_n | input | 1 | 0 = load new address, 1 = advance burst |
| we_n | input | 1 | 0 = write, 1 = read, sampled on loads |
| bw_n | input | NUM_BYTES | Active-low byte write strobes, data phase |
| addr | input | ADDR_W | Word address |
| wdata | input | NUM_BYTES*BYTE_W | Write data, data phase |
| rdata | output | NUM_BYTES*BYTE_W | Registered read data |
| rvalid | output | 1 | High in the cycle after a read access |

## Verification
The properties take for granted that the inputs are stable around each rising edge, and that `bw_n` and `wdata` are driven to known values on every enabled edge that completes a write. The burst property also assumes that an advance edge only occurs after a load has set a direction. The stimulus changes inputs only on falling edges. It starts with full-word write bursts that cover every address, so every later read targets a defined word, and it keeps the strobes defined in every cycle, including frozen and deselected ones.

// File: rtl/sram_ft_pkg.sv
package sram_ft_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } burst_st_e;

    localparam int BURST_BITS = 2;

endpackage

// File: rtl/sram_ft_ctl.sv
module sram_ft_ctl
    import sram_ft_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      ld_n,
    input  logic      sel_n,
    input  logic      we_n,
    output burst_st_e st,
    output logic      do_rd,
    output logic      do_wr,
    output logic      do_load
);

    burst_st_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_IDLE;
        else if (en)
            st <= nxt;
    end

    // transitions
    always_comb begin
        nxt = st;
        if (!ld_n) begin
            if (sel_n)     nxt = ST_IDLE;
            else if (we_n) nxt = ST_READ;
            else           nxt = ST_WRITE;
        end else begin
            unique case (st)
                ST_IDLE:  nxt = ST_IDLE;
                ST_READ:  nxt = ST_READ;
                ST_WRITE: nxt = ST_WRITE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        do_rd   = en && (nxt == ST_READ);
        do_wr   = en && (nxt == ST_WRITE);
        do_load = en && !ld_n && !sel_n;
    end

endmodule

// File: rtl/sram_ft_burst.sv
module sram_ft_burst
    import sram_ft_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_load,
    input  logic          do_adv,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] eff_addr
);

    localparam int LOW = BURST_BITS;

    logic [AW-1:0]  cur_addr;
    logic [LOW-1:0] step;

    assign step = cur_addr[LOW-1:0] + LOW'(1);

    generate
        if (AW > LOW) begin : g_upper
            assign eff_addr = do_load ? addr_in : {cur_addr[AW-1:LOW], step};
        end else begin : g_only_low
            assign eff_addr = do_load ? addr_in : step;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_addr <= '0;
        else if (do_load || do_adv)
            cur_addr <= eff_addr;
    end

endmodule

// File: rtl/sram_ft_array.sv
module sram_ft_array #(
    parameter int AW = 6,
    parameter int NB = 2,
    parameter int BW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr_en,
    input  logic [AW-1:0]    waddr,
    input  logic [NB-1:0]    bw_n,
    input  logic [NB*BW-1:0] wdata,
    input  logic             rd_en,
    input  logic [AW-1:0]    raddr,
    output logic [NB*BW-1:0] rdata
);

    localparam int DW    = NB * BW;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] mem_word;
    logic [DW-1:0] fwd_word;
    logic          hit;

    always_ff @(posedge clk) begin
        if (en && wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (!bw_n[b])
                    mem[waddr][b*BW +: BW] <= wdata[b*BW +: BW];
            end
        end
    end

    assign mem_word = mem[raddr];
    assign hit      = wr_en && (waddr == raddr);

    generate
        for (genvar g = 0; g < NB; g++) begin : g_lane
            assign fwd_word[g*BW +: BW] = (hit && !bw_n[g]) ? wdata[g*BW +: BW]
                                                             : mem_word[g*BW +: BW];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (en && rd_en)
            rdata <= fwd_word;
    end

endmodule

// File: rtl/sram_ft_top.sv
module sram_ft_top
    import sram_ft_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_BYTES = 2,
    parameter int BYTE_W    = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ce_n,
    input  logic                        sel_n,
    input  logic                        ld_n,
    input  logic                        we_n,
    input  logic [NUM_BYTES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_BYTES*BYTE_W-1:0] wdata,
    output logic [NUM_BYTES*BYTE_W-1:0] rdata,
    output logic                        rvalid
);

    logic          en;
    burst_st_e     st;
    logic          do_rd, do_wr, do_load, do_adv;
    logic [ADDR_W-1:0] eff_addr;
    logic          pw_valid;
    logic [ADDR_W-1:0] pw_addr;

    assign en     = !ce_n;
    assign do_adv = en && ld_n && (st != ST_IDLE);

    sram_ft_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .ld_n    (ld_n),
        .sel_n   (sel_n),
        .we_n    (we_n),
        .st      (st),
        .do_rd   (do_rd),
        .do_wr   (do_wr),
        .do_load (do_load)
    );

    sram_ft_burst #(.AW(ADDR_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_load  (do_load),
        .do_adv   (do_adv),
        .addr_in  (addr),
        .eff_addr (eff_addr)
    );

    // pending write: address now, data on the next enabled edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw_valid <= 1'b0;
            pw_addr  <= '0;
        end else if (en) begin
            pw_valid <= do_wr;
            pw_addr  <= eff_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rvalid <= 1'b0;
        else if (en)
            rvalid <= do_rd;
    end

    sram_ft_array #(.AW(ADDR_W), .NB(NUM_BYTES), .BW(BYTE_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .wr_en (pw_valid),
        .waddr (pw_addr),
        .bw_n  (bw_n),
        .wdata (wdata),
        .rd_en (do_rd),
        .raddr (eff_addr),
        .rdata (rdata)
    );

endmodule

// File: rtl/sram_ft_chk.sv
module sram_ft_chk
    import sram_ft_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          ld_n,
    input logic          sel_n,
    input logic          we_n,
    input logic          rvalid,
    input logic [DW-1:0] rdata,
    input burst_st_e     st,
    input logic [AW-1:0] pw_addr
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!rvalid && rdata == '0));

    p_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !ld_n && !sel_n && we_n) |=> rvalid);

    p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !ld_n && !sel_n && !we_n) |=> !rvalid);

    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> ($stable(rdata) && $stable(rvalid)));

    p_burst_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && ld_n && st == ST_WRITE) |=>
        ((pw_addr[1:0] == $past(pw_addr[1:0]) + 2'd1) &&
         (pw_addr[AW-1:2] == $past(pw_addr[AW-1:2]))));

    p_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !ld_n && sel_n) |=> (!rvalid && st == ST_IDLE));

endmodule

bind sram_ft_top sram_ft_chk #(.AW(ADDR_W), .DW(NUM_BYTES*BYTE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .ld_n    (ld_n),
    .sel_n   (sel_n),
    .we_n    (we_n),
    .rvalid  (rvalid),
    .rdata   (rdata),
    .st      (st),
    .pw_addr (pw_addr)
);

// File: tb/tb_sram_ft_top.sv
`timescale 1ns/1ps
module tb_sram_ft_top;

    localparam int AW    = 6;
    localparam int NB    = 2;
    localparam int BW    = 9;
    localparam int DW    = NB * BW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, sel_n = 1'b1, ld_n = 1'b1, we_n = 1'b1;
    logic [NB-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    sram_ft_top #(.ADDR_W(AW), .NUM_BYTES(NB), .BYTE_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sel_n(sel_n), .ld_n(ld_n),
        .we_n(we_n), .bw_n(bw_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    // behavioural reference: 0 idle, 1 read burst, 2 write burst
    logic [DW-1:0] ref_mem [DEPTH];
    int            m_mode;
    int            m_addr;
    bit            m_pend;
    int            m_paddr;
    logic [DW-1:0] m_rdata;
    bit            m_rvalid;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_addr = 0; m_pend = 0; m_paddr = 0;
            m_rdata = '0; m_rvalid = 0;
        end else if (!ce_n) begin
            int nmode;
            int na;
            if (!ld_n) begin
                nmode = sel_n ? 0 : (we_n ? 1 : 2);
                na    = int'(addr);
            end else begin
                nmode = m_mode;
                na    = (m_addr / 4) * 4 + ((m_addr % 4) + 1) % 4;
            end
            if (m_pend) begin
                for (int b = 0; b < NB; b++)
                    if (!bw_n[b]) ref_mem[m_paddr][b*BW +: BW] = wdata[b*BW +: BW];
            end
            if (nmode == 1) m_rdata = ref_mem[na];
            m_rvalid = (nmode == 1);
            m_pend   = (nmode == 2);
            m_paddr  = na;
            if (nmode != 0) m_addr = na;
            m_mode = nmode;
        end
    end

    function automatic logic [DW-1:0] pat(int a);
        return DW'(a * 2741 + 'h15A3C);
    endfunction

    task automatic compare();
        n_cmp++;
        if (rvalid !== m_rvalid || rdata !== m_rdata) begin
            n_bad++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     cur_req, rvalid, rdata, m_rvalid, m_rdata);
        end
    endtask

    task automatic tick(input logic c, input logic l, input logic s, input logic w,
                        input int a, input logic [NB-1:0] b, input logic [DW-1:0] d);
        @(negedge clk);
        compare();
        ce_n = c; ld_n = l; sel_n = s; we_n = w;
        addr = AW'(a); bw_n = b; wdata = d;
    endtask

    initial begin
        int prev;
        // R1: reset state
        repeat (3) @(negedge clk);
        n_cmp++;
        if (rvalid !== 1'b0 || rdata !== '0) begin
            n_bad++;
            $display("FAIL R1: rvalid=%0b rdata=%h expected rvalid=0 rdata=0", rvalid, rdata);
        end
        rst_n = 1'b1;

        // R3 / R7: write bursts fill every word, data one cycle late
        cur_req = "R3";
        prev = -1;
        for (int i = 0; i < DEPTH / 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                tick(1'b0, (j == 0) ? 1'b0 : 1'b1, 1'b0, 1'b0, i * 4,
                     (prev < 0) ? 2'b11 : 2'b00, (prev < 0) ? '0 : pat(prev));
                prev = i * 4 + j;
            end
        end
        tick(1'b0, 1'b0, 1'b1, 1'b1, 0, 2'b00, pat(prev));

        // R2: single reads, strobes low with junk data (R5: no effect)
        cur_req = "R2";
        for (int i = 0; i < 8; i++) tick(1'b0, 1'b0, 1'b0, 1'b1, i * 7 + 3, 2'b00, '1);
        cur_req = "R5";
        tick(1'b0, 1'b0, 1'b0, 1'b1, 3, 2'b00, 18'h2AAAA);
        tick(1'b0, 1'b0, 1'b0, 1'b1, 10, 2'b00, 18'h15555);

        // R7: read burst from low bits 2 wraps 2,3,0,1
        cur_req = "R7";
        tick(1'b0, 1'b0, 1'b0, 1'b1, 22, 2'b00, '1);
        for (int j = 0; j < 5; j++) tick(1'b0, 1'b1, 1'b0, 1'b0, 0, 2'b11, '0);

        // R4: single-lane writes then read back
        cur_req = "R4";
        tick(1'b0, 1'b0, 1'b0, 1'b0, 5, 2'b11, '0);
        tick(1'b0, 1'b0, 1'b1, 1'b1, 0, 2'b10, 18'h3FFFF);
        tick(1'b0, 1'b0, 1'b0, 1'b0, 6, 2'b11, '0);
        tick(1'b0, 1'b0, 1'b0, 1'b1, 5, 2'b01, 18'h1FE00);
        tick(1'b0, 1'b0, 1'b0, 1'b1, 6, 2'b00, '1);

        // R8: read directly after write to the same address
        cur_req = "R8";
        tick(1'b0, 1'b0, 1'b0, 1'b0, 9, 2'b11, '0);
        tick(1'b0, 1'b0, 1'b0, 1'b1, 9, 2'b01, 18'h0ABCD);
        tick(1'b0, 1'b0, 1'b0, 1'b0, 9, 2'b11, '0);
        tick(1'b0, 1'b0, 1'b0, 1'b1, 9, 2'b00, 18'h12345);
        tick(1'b0, 1'b0, 1'b1, 1'b1, 0, 2'b11, '0);

        // R6: clock enable high freezes outputs and the pending write
        cur_req = "R6";
        tick(1'b0, 1'b0, 1'b0, 1'b1, 17, 2'b11, '0);
        for (int j = 0; j < 3; j++) tick(1'b1, 1'b0, 1'b0, 1'b0, 40 + j, 2'b00, '1);
        tick(1'b0, 1'b0, 1'b0, 1'b0, 30, 2'b11, '0);
        for (int j = 0; j < 3; j++) tick(1'b1, 1'b0, 1'b0, 1'b1, 31, 2'b00, 18'h3C3C3);
        tick(1'b0, 1'b0, 1'b0, 1'b1, 30, 2'b00, 18'h24924);

        // R9: deselect, advance while idle, strobes ignored
        cur_req = "R9";
        tick(1'b0, 1'b0, 1'b1, 1'b0, 12, 2'b00, '1);
        tick(1'b0, 1'b1, 1'b0, 1'b0, 12, 2'b00, '1);
        tick(1'b0, 1'b1, 1'b0, 1'b1, 12, 2'b00, '1);
        tick(1'b0, 1'b0, 1'b0, 1'b1, 12, 2'b00, '1);
        tick(1'b0, 1'b1, 1'b0, 1'b1, 0, 2'b00, '1);

        // R2: mixed back-to-back traffic
        cur_req = "R2";
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom_range(0, 15));
            tick((r == 0) ? 1'b1 : 1'b0, (r < 4) ? 1'b1 : 1'b0, (r == 15) ? 1'b1 : 1'b0,
                 r[0], int'($urandom_range(0, DEPTH - 1)),
                 NB'($urandom_range(0, 3)), DW'($urandom));
        end
        tick(1'b0, 1'b0, 1'b1, 1'b1, 0, 2'b00, '0);
        tick(1'b0, 1'b0, 1'b1, 1'b1, 0, 2'b11, '0);
        @(negedge clk);
        compare();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule